// File: doc/BRIEF.md
# Two-Thread Barrier Synchronization Unit

This block holds two instruction streams, A and B, at a shared barrier until every participating thread has arrived. The two streams take turns through a one-bit grant input. Only the granted stream can move its own barrier state or the shared counters in a given cycle. Each stream has its own five-state barrier register. The streams share an arrival counter and a departure counter.

A new barrier episode cannot open until every thread has left the previous one. A thread that returns to the barrier early is parked until the departure counter drains to zero.

The unit takes each stream's current opcode and current program counter. It returns the program counter each stream should fetch next. A barrier instruction keeps its stream's program counter in place until that stream's barrier state reaches the done state. The number of participating threads is a parameter, and its default is two.

Top module: `barrier_sync_unit`

## Requirements
- R1: A synchronous active-high reset puts both barrier states in IDLE and clears both counters to zero. The state codes are IDLE=0, ARRIVE=1, PARK=2, RELEASE=3, DONE=4.
- R2: A stream's barrier state holds in any cycle where that stream is not granted, and in any cycle where its opcode is not the barrier opcode. The grant input is 0 for A and 1 for B.
- R3: For a granted stream with the barrier opcode, IDLE goes to ARRIVE and DONE goes to IDLE. Neither counter changes on these two steps.
- R4: For a granted stream with the barrier opcode in ARRIVE, a nonzero departure counter keeps the stream in ARRIVE and leaves both counters unchanged.
- R5: For a granted stream with the barrier opcode in ARRIVE, with a zero departure counter, the arrival counter increments.
  - If the arrival counter was one less than the thread count, the stream goes to RELEASE and the departure counter loads the thread count.
  - Otherwise the stream goes to PARK.
- R6: For a granted stream with the barrier opcode in PARK, the stream goes to RELEASE when the arrival counter equals the thread count. Otherwise it stays in PARK.
- R7: For a granted stream with the barrier opcode in RELEASE, the departure counter decrements and the stream goes to DONE. If the departure counter was 1, the arrival counter clears to zero.
- R8: Each next program counter is combinational and follows these rules:
  - A granted stream advances by 4 on a non-barrier opcode.
  - A granted stream on the barrier opcode advances by 4 only in DONE, and otherwise holds.
  - A stream that is not granted holds.
- R9: The shared counters take their next values only from the granted stream. A barrier opcode on the stream that is not granted leaves both counters unchanged.
- R10: Under any grant sequence, no stream reaches DONE for its n-th time before the other stream has left ARRIVE for PARK or RELEASE at least n times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| grant_b | input | 1 | Grant select: 0 grants stream A, 1 grants stream B |
| op_a | input | OP_W | Current opcode of stream A |
| op_b | input | OP_W | Current opcode of stream B |
| pc_a | input | PC_W | Current program counter of stream A |
| pc_b | input | PC_W | Current program counter of stream B |
| pc_a_next | output | PC_W | Next program counter of stream A |
| pc_b_next | output | PC_W | Next program counter of stream B |
| state_a | output | 3 | Barrier state of stream A |
| state_b | output | 3 | Barrier state of stream B |
| arrive_cnt | output | CNT_W | Shared arrival counter |
| depart_cnt | output | CNT_W | Shared departure counter |

## Verification
The hardest case to reach from the ports is a stream that comes back to ARRIVE while the other stream is still in RELEASE, so the departure counter is nonzero and the stall must hold. The directed vector table gets there in two ways. First, it lets stream A finish an episode and re-arm before B has left RELEASE. Later it does the same with the roles swapped, and confirms that the parked stream proceeds once the counter drains. A long run with random grants and a mostly-barrier opcode mix then checks the ordering rule of R10 at every step.

// File: rtl/barrier_pkg.sv
package barrier_pkg;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_ARRIVE  = 3'd1,
        ST_PARK    = 3'd2,
        ST_RELEASE = 3'd3,
        ST_DONE    = 3'd4
    } bstate_e;

    localparam int STATE_W  = 3;
    localparam int NUM_LANE = 2;

    function automatic int cnt_width(input int threads);
        return (threads < 1) ? 1 : $clog2(threads + 1);
    endfunction

endpackage

// File: rtl/barrier_lane.sv
module barrier_lane
    import barrier_pkg::*;
#(
    parameter int NUM_THREADS = 2,
    parameter int CNT_W       = 2,
    parameter int OP_W        = 8,
    parameter logic [OP_W-1:0] BAR_OP = 8'h2A
) (
    input  logic             granted,
    input  logic [OP_W-1:0]  opcode,
    input  bstate_e          cur,
    input  logic [CNT_W-1:0] arrive_q,
    input  logic [CNT_W-1:0] depart_q,
    output bstate_e          nxt,
    output logic [CNT_W-1:0] arrive_d,
    output logic [CNT_W-1:0] depart_d,
    output logic             is_bar
);
    localparam logic [CNT_W-1:0] LAST_IN = CNT_W'(NUM_THREADS - 1);
    localparam logic [CNT_W-1:0] FULL    = CNT_W'(NUM_THREADS);
    localparam logic [CNT_W-1:0] ONE     = CNT_W'(1);

    assign is_bar = (opcode == BAR_OP);

    always_comb begin
        nxt      = cur;
        arrive_d = arrive_q;
        depart_d = depart_q;
        if (granted && is_bar) begin
            unique case (cur)
                ST_IDLE: nxt = ST_ARRIVE;
                ST_ARRIVE: begin
                    if (depart_q == '0) begin
                        arrive_d = arrive_q + ONE;
                        if (arrive_q == LAST_IN) begin
                            nxt      = ST_RELEASE;
                            depart_d = FULL;
                        end else begin
                            nxt = ST_PARK;
                        end
                    end
                end
                ST_PARK: begin
                    if (arrive_q == FULL) nxt = ST_RELEASE;
                end
                ST_RELEASE: begin
                    depart_d = depart_q - ONE;
                    nxt      = ST_DONE;
                    if (depart_q == ONE) arrive_d = '0;
                end
                ST_DONE: nxt = ST_IDLE;
                default: nxt = cur;
            endcase
        end
    end
endmodule

// File: rtl/barrier_pc_step.sv
module barrier_pc_step
    import barrier_pkg::*;
#(
    parameter int PC_W = 32,
    parameter int STEP = 4
) (
    input  logic            granted,
    input  logic            is_bar,
    input  bstate_e         cur,
    input  logic [PC_W-1:0] pc,
    output logic [PC_W-1:0] pc_nxt
);
    logic advance;

    assign advance = granted && (!is_bar || (cur == ST_DONE));
    assign pc_nxt  = advance ? (pc + PC_W'(STEP)) : pc;
endmodule

// File: rtl/barrier_sync_unit.sv
module barrier_sync_unit
    import barrier_pkg::*;
#(
    parameter int NUM_THREADS = 2,
    parameter int OP_W        = 8,
    parameter int PC_W        = 32,
    parameter logic [OP_W-1:0] BAR_OP = 8'h2A,
    parameter int CNT_W       = cnt_width(NUM_THREADS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             grant_b,
    input  logic [OP_W-1:0]  op_a,
    input  logic [OP_W-1:0]  op_b,
    input  logic [PC_W-1:0]  pc_a,
    input  logic [PC_W-1:0]  pc_b,
    output logic [PC_W-1:0]  pc_a_next,
    output logic [PC_W-1:0]  pc_b_next,
    output logic [2:0]       state_a,
    output logic [2:0]       state_b,
    output logic [CNT_W-1:0] arrive_cnt,
    output logic [CNT_W-1:0] depart_cnt
);
    bstate_e          st_q   [NUM_LANE];
    bstate_e          st_d   [NUM_LANE];
    logic [CNT_W-1:0] arr_d  [NUM_LANE];
    logic [CNT_W-1:0] dep_d  [NUM_LANE];
    logic             bar_hit[NUM_LANE];
    logic [OP_W-1:0]  ops    [NUM_LANE];
    logic [PC_W-1:0]  pcs    [NUM_LANE];
    logic [PC_W-1:0]  pcn    [NUM_LANE];
    logic [CNT_W-1:0] arr_q, dep_q;
    logic [CNT_W-1:0] arr_sel, dep_sel;

    assign ops[0] = op_a;
    assign ops[1] = op_b;
    assign pcs[0] = pc_a;
    assign pcs[1] = pc_b;

    for (genvar t = 0; t < NUM_LANE; t++) begin : g_lane
        logic granted;
        assign granted = (grant_b == 1'(t));

        barrier_lane #(
            .NUM_THREADS(NUM_THREADS),
            .CNT_W      (CNT_W),
            .OP_W       (OP_W),
            .BAR_OP     (BAR_OP)
        ) lane_i (
            .granted (granted),
            .opcode  (ops[t]),
            .cur     (st_q[t]),
            .arrive_q(arr_q),
            .depart_q(dep_q),
            .nxt     (st_d[t]),
            .arrive_d(arr_d[t]),
            .depart_d(dep_d[t]),
            .is_bar  (bar_hit[t])
        );

        barrier_pc_step #(
            .PC_W(PC_W),
            .STEP(4)
        ) pc_i (
            .granted(granted),
            .is_bar (bar_hit[t]),
            .cur    (st_q[t]),
            .pc     (pcs[t]),
            .pc_nxt (pcn[t])
        );

        always_ff @(posedge clk) begin
            if (rst) st_q[t] <= ST_IDLE;
            else     st_q[t] <= st_d[t];
        end
    end

    assign arr_sel = grant_b ? arr_d[1] : arr_d[0];
    assign dep_sel = grant_b ? dep_d[1] : dep_d[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            arr_q <= '0;
            dep_q <= '0;
        end else begin
            arr_q <= arr_sel;
            dep_q <= dep_sel;
        end
    end

    assign pc_a_next  = pcn[0];
    assign pc_b_next  = pcn[1];
    assign state_a    = st_q[0];
    assign state_b    = st_q[1];
    assign arrive_cnt = arr_q;
    assign depart_cnt = dep_q;
endmodule

// File: rtl/barrier_sync_chk.sv
module barrier_sync_chk #(
    parameter int NUM_THREADS = 2,
    parameter int OP_W        = 8,
    parameter int PC_W        = 32,
    parameter logic [OP_W-1:0] BAR_OP = 8'h2A,
    parameter int CNT_W       = 2
) (
    input logic             clk,
    input logic             rst,
    input logic             grant_b,
    input logic [OP_W-1:0]  op_a,
    input logic [OP_W-1:0]  op_b,
    input logic [PC_W-1:0]  pc_a,
    input logic [PC_W-1:0]  pc_b,
    input logic [PC_W-1:0]  pc_a_next,
    input logic [PC_W-1:0]  pc_b_next,
    input logic [2:0]       state_a,
    input logic [2:0]       state_b,
    input logic [CNT_W-1:0] arrive_cnt,
    input logic [CNT_W-1:0] depart_cnt
);
    logic act_a, act_b;
    assign act_a = !grant_b && (op_a == BAR_OP);
    assign act_b =  grant_b && (op_b == BAR_OP);

    p_reset_r1: assert property (@(posedge clk)
        rst |=> (state_a == 3'd0 && state_b == 3'd0 && arrive_cnt == '0 && depart_cnt == '0));

    p_hold_a_r2: assert property (@(posedge clk) disable iff (rst)
        !act_a |=> $stable(state_a));

    p_hold_b_r2: assert property (@(posedge clk) disable iff (rst)
        !act_b |=> $stable(state_b));

    p_done_a_r3: assert property (@(posedge clk) disable iff (rst)
        (act_a && state_a == 3'd4) |=> (state_a == 3'd0 && $stable(arrive_cnt)));

    p_stall_a_r4: assert property (@(posedge clk) disable iff (rst)
        (act_a && state_a == 3'd1 && depart_cnt != '0)
            |=> (state_a == 3'd1 && $stable(arrive_cnt) && $stable(depart_cnt)));

    p_last_b_r5: assert property (@(posedge clk) disable iff (rst)
        (act_b && state_b == 3'd1 && depart_cnt == '0 && arrive_cnt == CNT_W'(NUM_THREADS - 1))
            |=> (state_b == 3'd3 && depart_cnt == CNT_W'(NUM_THREADS)));

    p_park_a_r6: assert property (@(posedge clk) disable iff (rst)
        (act_a && state_a == 3'd2 && arrive_cnt != CNT_W'(NUM_THREADS)) |=> state_a == 3'd2);

    p_release_a_r7: assert property (@(posedge clk) disable iff (rst)
        (act_a && state_a == 3'd3)
            |=> (state_a == 3'd4 && depart_cnt == $past(depart_cnt) - CNT_W'(1)));

    p_pc_hold_r8: assert property (@(posedge clk) disable iff (rst)
        grant_b |-> (pc_a_next == pc_a));

    p_cnt_idle_r9: assert property (@(posedge clk) disable iff (rst)
        (!act_a && !act_b) |=> ($stable(arrive_cnt) && $stable(depart_cnt)));
endmodule

bind barrier_sync_unit barrier_sync_chk #(
    .NUM_THREADS(NUM_THREADS),
    .OP_W       (OP_W),
    .PC_W       (PC_W),
    .BAR_OP     (BAR_OP),
    .CNT_W      (CNT_W)
) chk_i (
    .clk       (clk),
    .rst       (rst),
    .grant_b   (grant_b),
    .op_a      (op_a),
    .op_b      (op_b),
    .pc_a      (pc_a),
    .pc_b      (pc_b),
    .pc_a_next (pc_a_next),
    .pc_b_next (pc_b_next),
    .state_a   (state_a),
    .state_b   (state_b),
    .arrive_cnt(arrive_cnt),
    .depart_cnt(depart_cnt)
);

// File: tb/barrier_sync_unit_tb_top.sv
module barrier_sync_unit_tb_top;
    localparam logic [7:0] BAR = 8'h2A;
    localparam logic [7:0] NOP = 8'h01;
    localparam int NV = 25;

    // {grant_b, bar_a, bar_b, exp_a[3], exp_b[3], exp_arrive[2], exp_depart[2]}
    localparam logic [12:0] VEC [NV] = '{
        {1'b0,1'b0,1'b1,3'd0,3'd0,2'd0,2'd0},
        {1'b0,1'b1,1'b0,3'd1,3'd0,2'd0,2'd0},
        {1'b1,1'b1,1'b0,3'd1,3'd0,2'd0,2'd0},
        {1'b0,1'b1,1'b1,3'd2,3'd0,2'd1,2'd0},
        {1'b0,1'b1,1'b0,3'd2,3'd0,2'd1,2'd0},
        {1'b1,1'b0,1'b1,3'd2,3'd1,2'd1,2'd0},
        {1'b1,1'b0,1'b1,3'd2,3'd3,2'd2,2'd2},
        {1'b0,1'b1,1'b0,3'd3,3'd3,2'd2,2'd2},
        {1'b0,1'b1,1'b1,3'd4,3'd3,2'd2,2'd1},
        {1'b0,1'b1,1'b0,3'd0,3'd3,2'd2,2'd1},
        {1'b0,1'b1,1'b0,3'd1,3'd3,2'd2,2'd1},
        {1'b0,1'b1,1'b1,3'd1,3'd3,2'd2,2'd1},
        {1'b1,1'b1,1'b1,3'd1,3'd4,2'd0,2'd0},
        {1'b0,1'b1,1'b0,3'd2,3'd4,2'd1,2'd0},
        {1'b1,1'b0,1'b1,3'd2,3'd0,2'd1,2'd0},
        {1'b1,1'b0,1'b1,3'd2,3'd1,2'd1,2'd0},
        {1'b1,1'b1,1'b1,3'd2,3'd3,2'd2,2'd2},
        {1'b1,1'b0,1'b1,3'd2,3'd4,2'd2,2'd1},
        {1'b1,1'b0,1'b1,3'd2,3'd0,2'd2,2'd1},
        {1'b1,1'b0,1'b1,3'd2,3'd1,2'd2,2'd1},
        {1'b1,1'b0,1'b1,3'd2,3'd1,2'd2,2'd1},
        {1'b0,1'b0,1'b1,3'd2,3'd1,2'd2,2'd1},
        {1'b0,1'b1,1'b0,3'd3,3'd1,2'd2,2'd1},
        {1'b0,1'b1,1'b0,3'd4,3'd1,2'd0,2'd0},
        {1'b1,1'b1,1'b1,3'd4,3'd2,2'd1,2'd0}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        grant_b = 1'b0;
    logic [7:0]  op_a = NOP, op_b = NOP;
    logic [31:0] pc_a = '0, pc_b = '0;
    logic [31:0] pc_a_next, pc_b_next;
    logic [2:0]  state_a, state_b;
    logic [1:0]  arrive_cnt, depart_cnt;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    barrier_sync_unit dut_i (
        .clk(clk), .rst(rst), .grant_b(grant_b),
        .op_a(op_a), .op_b(op_b), .pc_a(pc_a), .pc_b(pc_b),
        .pc_a_next(pc_a_next), .pc_b_next(pc_b_next),
        .state_a(state_a), .state_b(state_b),
        .arrive_cnt(arrive_cnt), .depart_cnt(depart_cnt)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    initial begin
        #(8 * 150000);
        checks++;
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [2:0] pa, pb;
        int ent_a, ent_b, fin_a, fin_b;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 state_a", 32'(state_a), 0);
        check("R1 state_b", 32'(state_b), 0);
        check("R1 arrive", 32'(arrive_cnt), 0);
        check("R1 depart", 32'(depart_cnt), 0);
        rst = 1'b0;

        // Directed vector table covering R2-R9
        pa = 3'd0;
        pb = 3'd0;
        for (int i = 0; i < NV; i++) begin
            logic [12:0] v;
            logic [31:0] ea, eb;
            v = VEC[i];
            grant_b = v[12];
            op_a    = v[11] ? BAR : NOP;
            op_b    = v[10] ? BAR : NOP;
            pc_a    = 32'(100 + i * 8);
            pc_b    = 32'(2000 + i * 4);
            #1;
            // R8: next PC from the rule and the prior expected state
            ea = pc_a;
            eb = pc_b;
            if (!v[12] && (!v[11] || pa == 3'd4)) ea = pc_a + 4;
            if ( v[12] && (!v[10] || pb == 3'd4)) eb = pc_b + 4;
            check("R8 pc_a_next", pc_a_next, ea);
            check("R8 pc_b_next", pc_b_next, eb);
            @(posedge clk);
            @(negedge clk);
            // R2 R3 R4 R5 R6 R7: states; R9: counters follow granted stream
            check("R2-state_a", 32'(state_a), 32'(v[9:7]));
            check("R2-state_b", 32'(state_b), 32'(v[6:4]));
            check("R9 arrive", 32'(arrive_cnt), 32'(v[3:2]));
            check("R9 depart", 32'(depart_cnt), 32'(v[1:0]));
            pa = v[9:7];
            pb = v[6:4];
        end

        // R10: ordering under random grants
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        ent_a = 0; ent_b = 0; fin_a = 0; fin_b = 0;
        pa = 3'd0;
        pb = 3'd0;
        for (int i = 0; i < 3000; i++) begin
            grant_b = 1'($urandom_range(0, 1));
            op_a = ($urandom_range(0, 7) != 0) ? BAR : NOP;
            op_b = ($urandom_range(0, 7) != 0) ? BAR : NOP;
            @(posedge clk);
            @(negedge clk);
            if (pa == 3'd1 && (state_a == 3'd2 || state_a == 3'd3)) ent_a++;
            if (pb == 3'd1 && (state_b == 3'd2 || state_b == 3'd3)) ent_b++;
            if (state_a == 3'd4 && pa != 3'd4) begin
                fin_a++;
                check("R10 A done vs B entries", 32'(fin_a <= ent_b), 1);
            end
            if (state_b == 3'd4 && pb != 3'd4) begin
                fin_b++;
                check("R10 B done vs A entries", 32'(fin_b <= ent_a), 1);
            end
            pa = state_a;
            pb = state_b;
        end
        check("R10 progress A", 32'(fin_a > 0), 1);
        check("R10 progress B", 32'(fin_b > 0), 1);

        // R1: reset in mid-run
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check("R1 mid state_a", 32'(state_a), 0);
        check("R1 mid state_b", 32'(state_b), 0);
        check("R1 mid arrive", 32'(arrive_cnt), 0);
        check("R1 mid depart", 32'(depart_cnt), 0);
        finish_run();
    end
endmodule